// File: doc/BRIEF.md
# Fixed-Frequency Current Chopper with Selectable Decay

This block decides, clock by clock, how one H-bridge winding is driven inside a fixed-frequency current-regulation loop. An external period tick opens each chopping period. The bridge is then driven in CHARGE for a fixed blanking window, and the block ignores the current comparator during that window. After blanking, the block watches a comparator that rises once the coil current reaches the set current. It then moves the bridge into a decay state. The decay behaviour is chosen by a 2-bit select input. The bridge mode output feeds the gate-drive logic, which is outside this block.

The block has three decay behaviours:
- **Slow:** charge until the threshold is reached, then slow decay for the rest of the period.
- **Fast:** charge until the threshold is reached, then fast decay for the rest of the period.
- **Mixed:** charge until the threshold, then slow decay, then a fast-decay tail over the last part of the period. If the comparator is already high when blanking ends, there is no charge phase, and the bridge uses fast decay until the period ends.

Period, blanking and tail lengths are parameters counted in system clock cycles. The comparator input is asynchronous and passes through a two-flop synchronizer. A synchronous enable turns the bridge off. After enable returns, the block waits for the next period tick before it drives the bridge again.

Top module: `chop_ctrl`

## Requirements
- R1: After reset the bridge mode is OFF (2'b11), and it stays OFF until the first cycle in which `period_tick` and `en` are both sampled high.
- R2: A clock edge that samples `period_tick` and `en` high restarts the period count at 0. The mode is CHARGE (2'b00) for the `BLANK_CYC` cycles that follow (counts 0 to BLANK_CYC-1), whatever the comparator does.
- R3: After blanking, the mode stays CHARGE until the synchronized comparator is high. A comparator level present during cycle k is acted on at the clock edge that ends cycle k+2.
- R4: With slow select (`decay_sel` = 2'b00), the mode moves from CHARGE to SLOW (2'b01) once the threshold is seen. It stays SLOW until the next tick, and it never returns to CHARGE without a tick.
- R5: With fast select (`decay_sel` = 2'b10), the mode moves from CHARGE to FAST (2'b10) once the threshold is seen, and it stays FAST until the next tick. SLOW never occurs.
- R6: With mixed select (`decay_sel` = 2'b01 or 2'b11), a threshold seen during the charge phase gives SLOW. From period count PERIOD_CYC-TAIL_CYC onward, the mode is FAST.
- R7: With mixed select, if the comparator seen at the end of blanking is already high, the mode goes straight to FAST and stays FAST until the next tick.
- R8: With mixed select, if the threshold is never seen, the mode stays CHARGE until count PERIOD_CYC-TAIL_CYC and is FAST from that count on.
- R9: An edge that samples `en` low makes the mode OFF in the next cycle. The mode then stays OFF, even after `en` returns high, until a tick is sampled with `en` high.
- R10: The decay select is captured on the tick edge. Changing it later in the period has no effect on that period.
- R11: A tick in the middle of a period restarts blanking immediately, whatever the current state.
- R12: With slow or fast select, if the comparator seen at the end of blanking is already high, the mode goes straight to SLOW or FAST, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Synchronous bridge enable; low forces OFF |
| period_tick | input | 1 | One-cycle pulse that starts a chopping period |
| cmp_async | input | 1 | Asynchronous comparator, high when coil current is at or above the set current |
| decay_sel | input | 2 | 00 slow, 10 fast, 01 or 11 mixed (the mixed codes cover a floating select) |
| bridge_mode | output | 2 | 00 CHARGE, 01 SLOW, 10 FAST, 11 OFF |

## Verification
The assertions assume that `period_tick` is a single-cycle pulse. The checker measures time since the last enabled tick with its own counter. The assertions also assume that the period parameters leave the tail start after the blanking end.

The stimulus drives each tick for exactly one cycle. It varies the interval between ticks and sometimes issues a second tick inside a period. It moves comparator edges across the blanking boundary and drops enable at random points. In every cycle, the bench compares `bridge_mode` with a cycle model built from the requirements. Directed periods then pin down the blanking edge, the synchronizer latency and the tail start.

// File: rtl/chop_pkg.sv
// Shared types for the current chopper: bridge drive codes, internal
// phases and the decoded decay selection.
package chop_pkg;

    typedef enum logic [1:0] {
        BR_CHARGE = 2'b00,
        BR_SLOW   = 2'b01,
        BR_FAST   = 2'b10,
        BR_OFF    = 2'b11
    } bridge_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BLANK,
        PH_CHARGE,
        PH_SLOW,
        PH_FAST
    } phase_e;

    typedef enum logic [1:0] {
        DK_SLOW  = 2'b00,
        DK_MIXED = 2'b01,
        DK_FAST  = 2'b10
    } decay_e;

    // Map the raw select pins; both codes with bit 0 set mean mixed.
    function automatic decay_e decode_decay(input logic [1:0] raw);
        case (raw)
            2'b00:   return DK_SLOW;
            2'b10:   return DK_FAST;
            default: return DK_MIXED;
        endcase
    endfunction

endpackage

// File: rtl/chop_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; output lags input by STAGES edges.
module chop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the input level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
// Period position counter. Restarts at 0 on an enabled tick and advances
// once per cycle while a period is active, saturating at PERIOD_CYC-1.
// Flags are decoded from the next count so the phase logic can change
// state in the same edge the count reaches a boundary.
// Assumes 1 <= BLANK_CYC < PERIOD_CYC - TAIL_CYC.
module chop_timer #(
    parameter int PERIOD_CYC = 1200,
    parameter int BLANK_CYC  = 100,
    parameter int TAIL_CYC   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    output logic blank_done,
    output logic in_tail
);
    localparam int CW = $clog2(PERIOD_CYC);
    localparam logic [CW-1:0] LAST_L  = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYC);
    localparam logic [CW-1:0] TAIL_L  = CW'(PERIOD_CYC - TAIL_CYC);

    logic [CW-1:0] cnt_q, cnt_n;

    // Next count: restart, saturating advance, or hold.
    always_comb begin
        if (restart)                       cnt_n = '0;
        else if (advance && cnt_q != LAST_L) cnt_n = cnt_q + 1'b1;
        else                               cnt_n = cnt_q;
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
    end

    assign blank_done = (cnt_n == BLANK_L);
    assign in_tail    = (cnt_n >= TAIL_L);
endmodule

// File: rtl/chop_fsm.sv
// Per-period phase machine. Captures the decay selection on each enabled
// tick, walks BLANK -> CHARGE -> decay, and applies the mixed-mode rules.
// Assumes tick is a single-cycle pulse and cmp is already synchronized.
module chop_fsm
    import chop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [1:0] sel_raw,
    input  logic       cmp,
    input  logic       blank_done,
    input  logic       in_tail,
    output logic       active,
    output decay_e     sel_q,
    output logic [1:0] mode
);
    phase_e ph_q, ph_n;
    decay_e sel_n;

    // Next phase and selection from the current phase and timer flags.
    always_comb begin
        ph_n  = ph_q;
        sel_n = sel_q;
        if (!en) begin
            ph_n = PH_IDLE;
        end else if (tick) begin
            ph_n  = PH_BLANK;
            sel_n = decode_decay(sel_raw);
        end else begin
            case (ph_q)
                PH_BLANK:
                    if (blank_done) begin
                        if (!cmp)                ph_n = PH_CHARGE;
                        else if (sel_q == DK_SLOW) ph_n = PH_SLOW;
                        else                     ph_n = PH_FAST;
                    end
                PH_CHARGE:
                    if (cmp) ph_n = (sel_q == DK_FAST) ? PH_FAST : PH_SLOW;
                default: ;
            endcase
            if (sel_q == DK_MIXED && ph_q != PH_IDLE && in_tail)
                ph_n = PH_FAST;
        end
    end

    // Register phase and captured selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            sel_q <= DK_SLOW;
        end else begin
            ph_q  <= ph_n;
            sel_q <= sel_n;
        end
    end

    // Map phase to bridge drive code.
    always_comb begin
        case (ph_q)
            PH_BLANK, PH_CHARGE: mode = BR_CHARGE;
            PH_SLOW:             mode = BR_SLOW;
            PH_FAST:             mode = BR_FAST;
            default:             mode = BR_OFF;
        endcase
    end

    assign active = (ph_q != PH_IDLE);
endmodule

// File: rtl/chop_ctrl.sv
// Top of the current chopper: synchronizer, period timer and phase
// machine. Period, blanking and tail lengths are in clock cycles.
// Assumes 1 <= BLANK_CYC < PERIOD_CYC - TAIL_CYC and TAIL_CYC >= 1.
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC  = 1200,
    parameter int BLANK_CYC   = 100,
    parameter int TAIL_CYC    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       period_tick,
    input  logic       cmp_async,
    input  logic [1:0] decay_sel,
    output logic [1:0] bridge_mode
);
    logic   cmp_s;
    logic   blank_done, in_tail, active;
    decay_e sel_cur;

    chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_async),
        .q     (cmp_s)
    );

    chop_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .BLANK_CYC  (BLANK_CYC),
        .TAIL_CYC   (TAIL_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (en && period_tick),
        .advance    (en && active),
        .blank_done (blank_done),
        .in_tail    (in_tail)
    );

    chop_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick       (period_tick),
        .sel_raw    (decay_sel),
        .cmp        (cmp_s),
        .blank_done (blank_done),
        .in_tail    (in_tail),
        .active     (active),
        .sel_q      (sel_cur),
        .mode       (bridge_mode)
    );
endmodule

// File: rtl/chop_ctrl_chk.sv
// Protocol checker for chop_ctrl. Keeps its own age counter since the
// last enabled tick, so window checks do not depend on the timer inside.
module chop_ctrl_chk
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 1200,
    parameter int BLANK_CYC  = 100,
    parameter int TAIL_CYC   = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       tick,
    input logic [1:0] mode,
    input decay_e     sel_q
);
    localparam int AW = $clog2(PERIOD_CYC + 1);
    localparam logic [AW-1:0] LAST_L  = AW'(PERIOD_CYC - 1);
    localparam logic [AW-1:0] BLANK_L = AW'(BLANK_CYC);
    localparam logic [AW-1:0] TAIL_L  = AW'(PERIOD_CYC - TAIL_CYC);

    logic          run;
    logic [AW-1:0] age;

    // Track whether a period is running and how far into it we are.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            age <= '0;
        end else if (!en) begin
            run <= 1'b0;
        end else if (tick) begin
            run <= 1'b1;
            age <= '0;
        end else if (run && age != LAST_L) begin
            age <= age + 1'b1;
        end
    end

    AST_TICK_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        en && tick |=> mode == 2'b00);                                      // R2
    AST_BLANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        run && age < BLANK_L |-> mode == 2'b00);                            // R2
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> mode == 2'b11);                                             // R9
    AST_OFF_UNTIL_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 && !(en && tick) |=> mode == 2'b11);                  // R1
    AST_NO_RECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        en && !tick && (mode == 2'b01 || mode == 2'b10) |=> mode == $past(mode) || mode == 2'b10); // R4
    AST_SLOW_NEVER_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        run && sel_q == DK_SLOW |-> mode != 2'b10);                         // R4
    AST_FAST_NEVER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run && sel_q == DK_FAST |-> mode != 2'b01);                         // R5
    AST_MIX_TAIL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        run && sel_q == DK_MIXED && age >= TAIL_L |-> mode == 2'b10);       // R6
endmodule

bind chop_ctrl chop_ctrl_chk #(
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .TAIL_CYC   (TAIL_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (period_tick),
    .mode  (bridge_mode),
    .sel_q (sel_cur)
);

// File: tb/test_chop_ctrl.sv
// Bench for chop_ctrl: random periods against a requirement-level cycle
// model, plus directed periods with hand-computed expectations.
module test_chop_ctrl;
    localparam int CLK_PER = 10;
    localparam int P = 20;
    localparam int B = 3;
    localparam int T = 4;
    localparam logic [1:0] CHG = 2'b00, SLW = 2'b01, FST = 2'b10, OFF = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       cmp = 1'b0;
    logic [1:0] dsel = 2'b00;
    logic [1:0] mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [1:0] hist [64];

    always #(CLK_PER/2) clk = ~clk;

    chop_ctrl #(.PERIOD_CYC(P), .BLANK_CYC(B), .TAIL_CYC(T)) i_chop_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .period_tick (tick),
        .cmp_async   (cmp),
        .decay_sel   (dsel),
        .bridge_mode (mode)
    );

    // Cycle model from the requirements. Phase: 0 off, 1 blank,
    // 2 charge, 3 slow, 4 fast. Select: 0 slow, 1 mixed, 2 fast.
    int m_s1, m_s2, m_cnt, m_ph, m_sel;
    logic [1:0] m_exp = OFF;

    function automatic int dec_sel(input logic [1:0] s);
        return (s == 2'b00) ? 0 : (s == 2'b10) ? 2 : 1;
    endfunction

    function automatic logic [1:0] ph_mode(input int ph);
        case (ph)
            1, 2:    return CHG;
            3:       return SLW;
            4:       return FST;
            default: return OFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_cnt = 0; m_ph = 0; m_sel = 0;
        end else begin
            if (!en) m_ph = 0;
            else if (tick) begin
                m_ph = 1; m_cnt = 0; m_sel = dec_sel(dsel);
            end else if (m_ph != 0) begin
                if (m_cnt < P - 1) m_cnt = m_cnt + 1;
                if (m_ph == 1 && m_cnt == B)
                    m_ph = (m_s2 == 0) ? 2 : (m_sel == 0) ? 3 : 4;
                else if (m_ph == 2 && m_s2 != 0)
                    m_ph = (m_sel == 2) ? 4 : 3;
                if (m_sel == 1 && m_cnt >= P - T) m_ph = 4;
            end
            m_s2 = m_s1;
            m_s1 = int'(cmp);
        end
        m_exp = ph_mode(m_ph);
    end

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bridge_mode=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One period: tick at k=0 (and k=tick2), comparator high for k in
    // [c_lo,c_hi], enable low for k in [e_lo,e_hi]; hist[k] is the mode
    // at period count k.
    task automatic run_period(input logic [1:0] sel_a, input logic [1:0] sel_b,
                              input int c_lo, input int c_hi,
                              input int e_lo, input int e_hi,
                              input int tick2, input int ncyc, input string tag);
        for (int k = 0; k < ncyc; k++) begin
            tick = (k == 0) || (k == tick2);
            en   = !(k >= e_lo && k <= e_hi);
            cmp  = (k >= c_lo && k <= c_hi);
            dsel = (k == 0) ? sel_a : sel_b;
            @(posedge clk);
            @(negedge clk);
            chk(tag, mode, m_exp);
            if (k < 64) hist[k] = mode;
        end
        tick = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        // R1: reset state and no start without a tick
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", mode, OFF);
        end
        rst_n = 1'b1;
        en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", mode, OFF);
        end

        // R2/R8: mixed, comparator pulse only inside blanking, never again
        run_period(2'b01, 2'b01, 0, 0, -1, -2, -1, 22, "R8");
        chk("R2", hist[0], CHG);
        chk("R2", hist[3], CHG);
        chk("R8", hist[15], CHG);
        chk("R8", hist[16], FST);

        // R7: mixed, comparator already high at blanking end
        run_period(2'b01, 2'b01, 0, 99, -1, -2, -1, 22, "R7");
        chk("R7", hist[2], CHG);
        chk("R7", hist[3], FST);
        chk("R7", hist[10], FST);

        // R6/R3: mixed (code 11), threshold at k=6
        run_period(2'b11, 2'b11, 6, 99, -1, -2, -1, 22, "R6");
        chk("R3", hist[7], CHG);
        chk("R6", hist[8], SLW);
        chk("R6", hist[15], SLW);
        chk("R6", hist[16], FST);

        // R4: slow select, threshold at k=6, comparator falls later
        run_period(2'b00, 2'b00, 6, 9, -1, -2, -1, 24, "R4");
        chk("R4", hist[8], SLW);
        chk("R4", hist[16], SLW);
        chk("R4", hist[22], SLW);

        // R5: fast select, threshold at k=6
        run_period(2'b10, 2'b10, 6, 99, -1, -2, -1, 22, "R5");
        chk("R5", hist[7], CHG);
        chk("R5", hist[8], FST);
        chk("R5", hist[18], FST);

        // R12: slow select with comparator high at blanking end
        run_period(2'b00, 2'b00, 0, 99, -1, -2, -1, 20, "R12");
        chk("R12", hist[3], SLW);

        // R9: enable low at k=10..11, then high with no tick
        run_period(2'b01, 2'b01, 6, 99, 10, 11, -1, 20, "R9");
        chk("R9", hist[9], SLW);
        chk("R9", hist[10], OFF);
        chk("R9", hist[14], OFF);

        // R10: slow captured at tick, fast applied afterwards is ignored
        run_period(2'b00, 2'b10, 6, 99, -1, -2, -1, 22, "R10");
        chk("R10", hist[8], SLW);
        chk("R10", hist[19], SLW);

        // R11: mixed, comparator high, second tick at k=10
        run_period(2'b01, 2'b01, 0, 99, -1, -2, 10, 22, "R11");
        chk("R11", hist[9], FST);
        chk("R11", hist[10], CHG);
        chk("R11", hist[12], CHG);
        chk("R11", hist[13], FST);

        // R3: random periods against the cycle model
        for (int n = 0; n < 150; n++) begin
            int lo, hi, elo, ehi, t2;
            lo  = $urandom_range(0, 20);
            hi  = ($urandom_range(0, 3) == 0) ? 99 : lo + $urandom_range(0, 10);
            elo = -1; ehi = -2; t2 = -1;
            if ($urandom_range(0, 4) == 0) begin
                elo = $urandom_range(1, 15);
                ehi = elo + $urandom_range(0, 4);
            end
            if ($urandom_range(0, 6) == 0) t2 = $urandom_range(2, 15);
            run_period(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                       lo, hi, elo, ehi, t2, $urandom_range(17, 26), "R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule